// File: doc/BRIEF.md
# Serial Register Port with Shadow/Active Update

This block is the slave end of a three- or four-wire serial control link. It gives an external controller access to a small file of 8-bit configuration registers. Each transfer opens with a 16-bit instruction word, which carries a read flag, a byte count and a start address. One data byte or a stream of data bytes follows. The address steps after every byte, and the active bit order decides whether it steps up or down. The serial pins are sampled with the system clock through a synchronizer, so all register state lives in the system clock domain.

Ordinary registers have two copies. A write lands in a shadow copy, and one command moves every shadow value into the active copy in the same clock. Reads always return the active copy. The mode register at address 0 has no shadow, so its bits act at once. These bits select the bit order, the pin that returns read data, and a sticky soft reset that holds every other register at its default.

Top module: `sreg_port`

## Requirements
- R1: An instruction is 16 bits. Bit 15 set means read. Bits 14:13 hold a count code, where 0, 1 and 2 mean 1, 2 and 3 data bytes and 3 means an open-ended stream. Bits 12:0 hold the start address. Data is sampled on rising SCLK while CSB is low, and read data changes after falling SCLK.
- R2: With mode bit 6 clear (after reset), the instruction and data travel most significant bit first, and the address decreases by one after each byte.
- R3: With mode bit 6 set, the instruction and data travel least significant bit first, and the address increases by one after each byte.
- R4: A write to address 0x00 acts from the next byte onward without the update command. Address 0x00 reads back bits 7:5 as written, bit 4 as 1 and bits 3:0 as 0.
- R5: A write to any other register changes only its shadow copy. Reads return the active copy, which does not change until an update or a soft reset.
- R6: Writing a byte with bit 0 set to address 0x5A copies every shadow register into its active register in one clock. Address 0x5A reads as 0.
- R7: The implemented fields are 0x04[5:0], 0x05[4:0], 0x06[7:0], 0x07 bits 6:5 and bit 2, and 0x08[1:0]. Every other bit and every other address reads 0 and ignores writes. The default of 0x06 is 0x01, and all other defaults are 0.
- R8: While mode bit 5 is set, every register other than 0x00 is held at its default, in both copies. Writes and update commands to those registers have no effect. The bit stays set until 0 is written to it.
- R9: With mode bit 7 set, read data is driven on SDIO (sdio_oe high, sdo_oe low). With the bit clear, read data is driven on SDO (sdo_oe high, sdio_oe low).
- R10: Raising CSB ends the transfer. A partly received byte is dropped, and both output enables go low.
- R11: The hardware reset loads every default, including 0x00, which reads 0x10.
- R12: When the count code is not 3, bytes beyond the stated count are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sclk | input | 1 | Serial clock from the controller |
| csb | input | 1 | Active-low transfer frame |
| sdio_in | input | 1 | Serial data from the controller |
| sdio_out | output | 1 | Read data for the bidirectional pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional pin |
| sdo_out | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Drive enable for the separate output pin |

## Verification
An update command and a held soft reset can fall in the same clock. The bench provokes this by loading a shadow value, setting the soft-reset bit, and then writing the update command while the bit is still set. It then reads the register and expects its default, and reads it again after the bit is cleared and another update is sent, expecting the default a second time. The stream sweep also writes the shadow of every address, reads the active copy before and after one update, and compares each byte with values that the bench derives from the field masks.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   localparam int unsigned INSTR_BITS = 16;
   localparam int unsigned ADDR_BITS  = 13;
   localparam int unsigned DATA_BITS  = 8;
   localparam int unsigned MODE_ADDR  = 0;
   localparam int unsigned LOAD_ADDR  = 'h5A;
   localparam int unsigned FILE_SIZE  = LOAD_ADDR + 1;

   // mode register bit positions
   localparam int unsigned MODE_PIN3W = 7;
   localparam int unsigned MODE_LSBF  = 6;
   localparam int unsigned MODE_SRST  = 5;

   typedef enum logic [1:0] {
      PH_INSTR = 2'd0,
      PH_DATA  = 2'd1,
      PH_DONE  = 2'd2
   } phase_e;

   function automatic logic [7:0] field_mask(int unsigned a);
      case (a)
         4:       return 8'h3F;
         5:       return 8'h1F;
         6:       return 8'hFF;
         7:       return 8'h64;
         8:       return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] field_default(int unsigned a);
      case (a)
         6:       return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int unsigned    W       = 1,
   parameter int unsigned    STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sreg_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_st
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[s] <= RST_VAL;
            else        st[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[s] <= RST_VAL;
            else        st[s] <= st[s-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/sreg_engine.sv
module sreg_engine
   import sreg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk_s,
   input  logic                 csb_s,
   input  logic                 sdi_s,
   input  logic                 lsb_first,
   input  logic [DATA_BITS-1:0] rd_byte,
   output logic [ADDR_BITS-1:0] cur_addr,
   output logic                 wr_en,
   output logic [ADDR_BITS-1:0] wr_addr,
   output logic [DATA_BITS-1:0] wr_data,
   output logic                 drive,
   output logic                 dout
);

   localparam int unsigned CNT_W = $clog2(INSTR_BITS) + 1;
   localparam int unsigned BIT_W = $clog2(DATA_BITS);

   phase_e                 ph_q;
   logic                   sclk_d;
   logic [CNT_W-1:0]       cnt_q;
   logic [INSTR_BITS-1:0]  ish_q, ish_n;
   logic [DATA_BITS-1:0]   dsh_q, dsh_n, obuf_q;
   logic                   rd_q, strm_q, load_q;
   logic [1:0]             left_q;
   logic [ADDR_BITS-1:0]   addr_q, addr_step;
   logic [BIT_W-1:0]       out_idx;
   logic                   rise, fall;

   assign rise = sclk_s & ~sclk_d & ~csb_s;
   assign fall = ~sclk_s & sclk_d & ~csb_s;

   assign ish_n = lsb_first ? {sdi_s, ish_q[INSTR_BITS-1:1]} : {ish_q[INSTR_BITS-2:0], sdi_s};
   assign dsh_n = lsb_first ? {sdi_s, dsh_q[DATA_BITS-1:1]} : {dsh_q[DATA_BITS-2:0], sdi_s};

   assign addr_step = lsb_first ? addr_q + ADDR_BITS'(1) : addr_q - ADDR_BITS'(1);
   assign out_idx   = lsb_first ? cnt_q[BIT_W-1:0] : BIT_W'(DATA_BITS - 1) - cnt_q[BIT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_INSTR;
         sclk_d  <= 1'b0;
         cnt_q   <= '0;
         ish_q   <= '0;
         dsh_q   <= '0;
         obuf_q  <= '0;
         rd_q    <= 1'b0;
         strm_q  <= 1'b0;
         load_q  <= 1'b0;
         left_q  <= '0;
         addr_q  <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         drive   <= 1'b0;
         dout    <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         wr_en  <= 1'b0;
         load_q <= 1'b0;
         if (load_q) obuf_q <= rd_byte;
         if (csb_s) begin
            ph_q  <= PH_INSTR;
            cnt_q <= '0;
            drive <= 1'b0;
         end else if (rise) begin
            case (ph_q)
               PH_INSTR: begin
                  ish_q <= ish_n;
                  if (cnt_q == CNT_W'(INSTR_BITS - 1)) begin
                     rd_q   <= ish_n[INSTR_BITS-1];
                     strm_q <= &ish_n[INSTR_BITS-2 -: 2];
                     left_q <= ish_n[INSTR_BITS-2 -: 2];
                     addr_q <= ish_n[ADDR_BITS-1:0];
                     ph_q   <= PH_DATA;
                     cnt_q  <= '0;
                     load_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               PH_DATA: begin
                  dsh_q <= dsh_n;
                  if (cnt_q == CNT_W'(DATA_BITS - 1)) begin
                     cnt_q  <= '0;
                     addr_q <= addr_step;
                     load_q <= 1'b1;
                     if (!rd_q) begin
                        wr_en   <= 1'b1;
                        wr_addr <= addr_q;
                        wr_data <= dsh_n;
                     end
                     if (!strm_q) begin
                        if (left_q == 2'd0) begin
                           ph_q  <= PH_DONE;
                           drive <= 1'b0;
                        end else begin
                           left_q <= left_q - 2'd1;
                        end
                     end
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               default: ;
            endcase
         end else if (fall && ph_q == PH_DATA && rd_q) begin
            dout  <= obuf_q[out_idx];
            drive <= 1'b1;
         end
      end
   end

   assign cur_addr = addr_q;

endmodule

// File: rtl/sreg_file.sv
module sreg_file
   import sreg_pkg::*;
#(
   parameter int unsigned NUM_REGS = FILE_SIZE,
   parameter int unsigned UPD_ADDR = LOAD_ADDR
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_BITS-1:0]       wr_addr,
   input  logic [DATA_BITS-1:0]       wr_data,
   input  logic [ADDR_BITS-1:0]       rd_addr,
   output logic [DATA_BITS-1:0]       rd_data,
   output logic [DATA_BITS-1:0]       mode,
   output logic                       upd_fire,
   output logic [NUM_REGS*DATA_BITS-1:0] act_img,
   output logic [NUM_REGS*DATA_BITS-1:0] shd_img
);

   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   logic [2:0]           mode_q;
   logic                 srst;
   logic [DATA_BITS-1:0] shd_arr [NUM_REGS];
   logic [DATA_BITS-1:0] act_arr [NUM_REGS];

   // mode register: no shadow, bits 7:5 stored, bit 4 fixed high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       mode_q <= 3'b000;
      else if (wr_en && wr_addr == ADDR_BITS'(MODE_ADDR)) mode_q <= wr_data[MODE_PIN3W:MODE_SRST];
   end

   assign mode     = {mode_q, 1'b1, 4'b0000};
   assign srst     = mode_q[MODE_SRST-5];
   assign upd_fire = wr_en && wr_addr == ADDR_BITS'(UPD_ADDR) && wr_data[0];

   for (genvar a = 0; a < NUM_REGS; a++) begin : g_reg
      localparam logic [DATA_BITS-1:0] MSK = field_mask(a);
      localparam logic [DATA_BITS-1:0] DEF = field_default(a) & MSK;
      if (a != MODE_ADDR && a != UPD_ADDR && MSK != '0) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  shd_arr[a] <= DEF;
            else if (srst)                               shd_arr[a] <= DEF;
            else if (wr_en && wr_addr == ADDR_BITS'(a))  shd_arr[a] <= wr_data & MSK;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        act_arr[a] <= DEF;
            else if (srst)     act_arr[a] <= DEF;
            else if (upd_fire) act_arr[a] <= shd_arr[a];
         end
      end else begin : g_none
         assign shd_arr[a] = '0;
         assign act_arr[a] = '0;
      end
      assign act_img[a*DATA_BITS +: DATA_BITS] = act_arr[a];
      assign shd_img[a*DATA_BITS +: DATA_BITS] = shd_arr[a];
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_BITS'(MODE_ADDR))     rd_data = mode;
      else if (rd_addr < ADDR_BITS'(NUM_REGS))  rd_data = act_arr[rd_addr[IDX_W-1:0]];
   end

endmodule

// File: rtl/sreg_port.sv
module sreg_port
   import sreg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NUM_REGS    = FILE_SIZE,
   parameter int unsigned UPD_ADDR    = LOAD_ADDR
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic csb,
   input  logic sdio_in,
   output logic sdio_out,
   output logic sdio_oe,
   output logic sdo_out,
   output logic sdo_oe
);

   if (NUM_REGS <= UPD_ADDR || NUM_REGS > (1 << ADDR_BITS)) begin : g_bad_size
      $error("sreg_port: NUM_REGS must exceed UPD_ADDR and fit the address field");
   end

   logic                          sclk_s, csb_s, sdi_s;
   logic [ADDR_BITS-1:0]          cur_addr, wr_addr;
   logic [DATA_BITS-1:0]          wr_data, rd_byte, cfg_w;
   logic                          wr_en, drive, dout, upd_w;
   logic [NUM_REGS*DATA_BITS-1:0] act_w, shd_w;

   sreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, csb, sdio_in}),
      .q     ({sclk_s, csb_s, sdi_s})
   );

   sreg_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .csb_s     (csb_s),
      .sdi_s     (sdi_s),
      .lsb_first (cfg_w[MODE_LSBF]),
      .rd_byte   (rd_byte),
      .cur_addr  (cur_addr),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .drive     (drive),
      .dout      (dout)
   );

   sreg_file #(.NUM_REGS(NUM_REGS), .UPD_ADDR(UPD_ADDR)) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (cur_addr),
      .rd_data  (rd_byte),
      .mode     (cfg_w),
      .upd_fire (upd_w),
      .act_img  (act_w),
      .shd_img  (shd_w)
   );

   assign sdio_out = dout;
   assign sdo_out  = dout;
   assign sdio_oe  = drive &  cfg_w[MODE_PIN3W];
   assign sdo_oe   = drive & ~cfg_w[MODE_PIN3W];

endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
   import sreg_pkg::*;
#(
   parameter int unsigned NUM_REGS = FILE_SIZE,
   parameter int unsigned UPD_ADDR = LOAD_ADDR
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          csb_s,
   input logic                          sdio_oe,
   input logic                          sdo_oe,
   input logic [DATA_BITS-1:0]          cfg,
   input logic                          upd_fire,
   input logic [NUM_REGS*DATA_BITS-1:0] act_img,
   input logic [NUM_REGS*DATA_BITS-1:0] shd_img
);

   function automatic logic [NUM_REGS*DATA_BITS-1:0] def_image();
      logic [NUM_REGS*DATA_BITS-1:0] img;
      img = '0;
      for (int a = 0; a < NUM_REGS; a++)
         if (a != MODE_ADDR && a != UPD_ADDR)
            img[a*DATA_BITS +: DATA_BITS] = field_default(a) & field_mask(a);
      return img;
   endfunction

   localparam logic [NUM_REGS*DATA_BITS-1:0] DEF_IMG = def_image();

   // R10
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csb_s |=> (!sdio_oe && !sdo_oe));

   // R9
   pin_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdio_oe && sdo_oe));

   // R6
   update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_fire && !cfg[MODE_SRST]) |=> act_img == $past(shd_img));

   // R5
   active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_fire && !cfg[MODE_SRST]) |=> $stable(act_img));

   // R8
   soft_reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[MODE_SRST] |=> (act_img == DEF_IMG && shd_img == DEF_IMG));

endmodule

bind sreg_port sreg_port_chk #(.NUM_REGS(NUM_REGS), .UPD_ADDR(UPD_ADDR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .csb_s    (csb_s),
   .sdio_oe  (sdio_oe),
   .sdo_oe   (sdo_oe),
   .cfg      (cfg_w),
   .upd_fire (upd_w),
   .act_img  (act_w),
   .shd_img  (shd_w)
);

// File: tb/sim_sreg_port.sv
module sim_sreg_port;

   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n, sclk, csb, sdio_in;
   logic sdio_out, sdio_oe, sdo_out, sdo_oe;

   always #10 clk = ~clk;

   sreg_port u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (sclk),
      .csb      (csb),
      .sdio_in  (sdio_in),
      .sdio_out (sdio_out),
      .sdio_oe  (sdio_oe),
      .sdo_out  (sdo_out),
      .sdo_oe   (sdo_oe)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [7:0] shd_m [128];
   logic [7:0] act_m [128];
   bit lsb_m, tw_m, sr_m;
   logic [7:0] wbuf [100];
   logic [7:0] rbuf [100];

   function automatic logic [7:0] m_mask(int a);
      case (a)
         4: return 8'h3F;
         5: return 8'h1F;
         6: return 8'hFF;
         7: return 8'h64;
         8: return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] m_def(int a);
      return (a == 6) ? 8'h01 : 8'h00;
   endfunction

   task automatic m_regs_default();
      for (int a = 0; a < 128; a++) begin
         shd_m[a] = m_def(a);
         act_m[a] = m_def(a);
      end
   endtask

   task automatic m_write(int a, logic [7:0] d);
      if (a == 0) begin
         tw_m = d[7]; lsb_m = d[6]; sr_m = d[5];
         if (sr_m) m_regs_default();
      end else if (sr_m) begin
      end else if (a == 'h5A) begin
         if (d[0]) for (int i = 0; i < 128; i++) act_m[i] = shd_m[i];
      end else if (a < 'h5A) begin
         shd_m[a] = d & m_mask(a);
      end
   endtask

   function automatic logic [7:0] m_read(int a);
      if (a == 0)    return {tw_m, lsb_m, sr_m, 1'b1, 4'b0000};
      if (a < 'h5A)  return act_m[a];
      return 8'h00;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, output logic got, output bit pin_ok);
      @(negedge clk) sdio_in = b;
      repeat (HALF) @(negedge clk);
      got    = tw_m ? sdio_out : sdo_out;
      pin_ok = tw_m ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic send_instr(input bit rd, input logic [1:0] code, input logic [12:0] a);
      logic [15:0] iw;
      logic g;
      bit p;
      iw = {rd, code, a};
      @(negedge clk) csb = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 16; i++) send_bit(lsb_m ? iw[i] : iw[15 - i], g, p);
   endtask

   task automatic end_frame();
      @(negedge clk) csb = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   // full transfer: n bytes from wbuf, read bytes checked against the model
   task automatic xfer(input bit rd, input logic [1:0] code, input logic [12:0] a, input int n, input string tag);
      logic [12:0] cur;
      int lim;
      bit pins_all, lsb_now;
      logic [7:0] exp;
      cur = a;
      lim = (code == 2'd3) ? 1000 : int'(code) + 1;
      pins_all = 1;
      send_instr(rd, code, a);
      for (int k = 0; k < n; k++) begin
         lsb_now = lsb_m;
         exp = m_read(int'(cur));
         for (int j = 0; j < 8; j++) begin
            logic g;
            bit p;
            int idx;
            idx = lsb_now ? j : 7 - j;
            send_bit(wbuf[k][idx], g, p);
            rbuf[k][idx] = g;
            if (rd && k < lim && !p) pins_all = 0;
         end
         if (k < lim) begin
            if (rd) chk(rbuf[k] === exp, tag, {3'b0, cur}, {8'h00, exp});
            else    m_write(int'(cur), wbuf[k]);
         end
         cur = lsb_now ? cur + 13'd1 : cur - 13'd1;
      end
      end_frame();
      if (rd) chk(pins_all, "R9 pin select", {15'd0, pins_all}, 16'd1);
   endtask

   task automatic wr1(input logic [12:0] a, input logic [7:0] d);
      wbuf[0] = d;
      xfer(1'b0, 2'd0, a, 1, "wr");
   endtask

   task automatic rd1(input logic [12:0] a, input string tag);
      wbuf[0] = 8'h00;
      xfer(1'b1, 2'd0, a, 1, tag);
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 1'b0; csb = 1'b1; sclk = 1'b0; sdio_in = 1'b0;
      lsb_m = 0; tw_m = 0; sr_m = 0;
      m_regs_default();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      hw_reset();

      // R11 R1: reset state of mode register and a nonzero default
      rd1(13'h000, "R11 mode reset");
      rd1(13'h006, "R1 single read default");

      // R2: descending stream fills every shadow, R5: active copy unchanged
      for (int k = 0; k < 89; k++) wbuf[k] = 8'hFF;
      xfer(1'b0, 2'd3, 13'h059, 89, "R2");
      for (int k = 0; k < 96; k++) wbuf[k] = 8'h00;
      xfer(1'b1, 2'd3, 13'h05F, 96, "R5 active before update");

      // R6: one update copies all shadows; R7: masks and unused space
      wr1(13'h05A, 8'h01);
      xfer(1'b1, 2'd3, 13'h05F, 96, "R6 after update");
      rd1(13'h007, "R7 field mask");
      rd1(13'h1000, "R7 out of range");
      rd1(13'h05A, "R6 update reads zero");

      // R12: two-byte count, third byte ignored
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      xfer(1'b0, 2'd1, 13'h008, 3, "R12");
      wr1(13'h05A, 8'h01);
      xfer(1'b1, 2'd2, 13'h008, 3, "R12 count limit");

      // R3 R4: mode write acts without update, then ascending LSB-first stream
      wr1(13'h000, 8'h40);
      rd1(13'h000, "R4 mode immediate");
      wbuf[0] = 8'h2A; wbuf[1] = 8'h13; wbuf[2] = 8'hC5;
      xfer(1'b0, 2'd3, 13'h004, 3, "R3");
      wr1(13'h05A, 8'h01);
      xfer(1'b1, 2'd2, 13'h004, 3, "R3 ascending");
      wr1(13'h000, 8'h4F);
      rd1(13'h000, "R4 fixed bits");

      // R9: three-wire read on SDIO, in both bit orders
      wr1(13'h000, 8'hC0);
      rd1(13'h004, "R9 three-wire lsb");
      wr1(13'h000, 8'h80);
      rd1(13'h005, "R9 three-wire msb");
      wr1(13'h000, 8'h00);

      // R10: partial write byte dropped
      send_instr(1'b0, 2'd0, 13'h004);
      for (int j = 0; j < 4; j++) begin
         logic g;
         bit p;
         send_bit(1'b1, g, p);
      end
      end_frame();
      wr1(13'h05A, 8'h01);
      rd1(13'h004, "R10 partial byte dropped");

      // R10: aborted read releases both pins
      send_instr(1'b1, 2'd0, 13'h006);
      for (int j = 0; j < 3; j++) begin
         logic g;
         bit p;
         send_bit(1'b0, g, p);
      end
      @(negedge clk) csb = 1'b1;
      repeat (5) @(negedge clk);
      chk(!sdio_oe && !sdo_oe, "R10 release", {14'd0, sdio_oe, sdo_oe}, 16'd0);
      repeat (4) @(negedge clk);

      // R8: soft reset held while an update arrives
      wr1(13'h004, 8'h15);
      wr1(13'h000, 8'h20);
      wr1(13'h004, 8'h3F);
      wr1(13'h05A, 8'h01);
      rd1(13'h004, "R8 update under soft reset");
      rd1(13'h000, "R8 sticky bit");
      wr1(13'h000, 8'h00);
      wr1(13'h05A, 8'h01);
      rd1(13'h004, "R8 shadow was reset");
      rd1(13'h006, "R8 default restored");

      // R11: hardware reset clears the mode register too
      wr1(13'h000, 8'hC0);
      wr1(13'h006, 8'h77);
      wr1(13'h05A, 8'h01);
      hw_reset();
      rd1(13'h000, "R11 mode after reset");
      rd1(13'h006, "R11 register after reset");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule